// File: doc/BRIEF.md
# Special Register Move Unit

This block serves the move-to-special-register and move-from-special-register operations of a small processor core. Each cycle it may receive one access: an 8-bit selector, a read strobe, a write strobe, 32-bit write data, and a flag that says whether the requesting code is privileged. It holds the special register file. That file contains a combined status word (condition flags, exception number, execution-state bits), two stack pointers kept as a live copy and a banked copy, the interrupt masks (single-bit priority mask, single-bit fault mask, multi-bit base priority) and a 2-bit control register.

Privilege gating and per-field masks apply on both reads and writes. Selectors 0 to 7 are views of the status word, and the selector bits choose which fields a view shows. Unprivileged code can read only the status views and the control register, and can write only the condition flags. A privileged access to a selector that no register uses returns zero, changes nothing, and raises a one-cycle error pulse, so execution carries on. The exception-number and execution-state fields come from a side-load port that the exception logic drives.

A small FSM records what the previous cycle did. It has four states: `ST_IDLE` (no access), `ST_READ` (read data is valid), `ST_WRITE` (a write was committed) and `ST_FAULT` (a privileged access hit an unknown selector). Every state is entered from any state on the next clock edge, as follows:
- A privileged access to an unknown selector goes to `ST_FAULT`.
- Otherwise, any write goes to `ST_WRITE`.
- Otherwise, a read goes to `ST_READ`.
- Otherwise, the FSM goes to `ST_IDLE`.

Top module: `sreg_access_unit`

## Requirements
- R1: After reset, every register holds zero, and `rd_data`, `rd_valid` and `sel_err` are low.
- R2: A read strobe sampled at clock edge N puts the result on `rd_data` with `rd_valid` high from edge N until edge N+1. A write sampled at edge N is visible to a read issued in the next cycle.
- R3: Selectors 0 to 7 are status views. When selector bit 2 is 0, the view includes flag bits [31:27]. When selector bit 0 is 1 and the access is privileged, the view includes exception-number bits [8:0].
- R4: The execution-state bits (mask 0x0700FC00) always read as zero through a status view. Only the side-load port sets them.
- R5: A write to any status view, at any privilege level, changes only bits [31:27]. The exception-number and execution-state bits stay unchanged.
- R6: An unprivileged read of any selector other than 0 to 7 and 20 returns zero. An unprivileged write to any selector above 7 is ignored. Neither case raises `sel_err`.
- R7: Selector 8 is the main stack pointer and selector 9 is the process stack pointer. Control bit 1 selects which of the two is live and which is banked. A value written to either pointer reads back unchanged after the active pointer is switched.
- R8: The control register at selector 20 holds 2 bits, reads zero-extended at any privilege level, and only a privileged write changes it.
- R9: The priority mask at selector 16 and the fault mask at selector 19 each store bit 0 of the written value and read as that bit zero-extended to 32 bits.
- R10: The base priority at selector 17 stores and returns the low PRIO_W bits (8 by default).
- R11: A write to selector 18 loads the base priority only if the new value is nonzero and either the current value is zero or the new value is lower than the current value. Otherwise the write is ignored.
- R12: A privileged access to an unknown selector (10 to 15, or above 20) changes no register, leaves `rd_valid` low with `rd_data` zero, and raises `sel_err` for exactly one cycle.
- R13: When read and write strobes are both high, only the write is performed and no read response appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 8 | Special register selector |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| priv | input | 1 | High when the requesting code is privileged |
| xs_load | input | 1 | Side load of exception-number and execution-state fields |
| xs_data | input | 32 | Side-load value; only bits [8:0] and mask 0x0700FC00 are used |
| rd_data | output | 32 | Registered read result |
| rd_valid | output | 1 | High for one cycle with each read result |
| sel_err | output | 1 | One-cycle pulse on a privileged access to an unknown selector |

## Verification
Read data, `rd_valid` and `sel_err` are all due one clock edge after the strobe is sampled. Register updates from a write or a side load are due at that same edge, so they are visible to a read issued in the following cycle. The bench drives each access on a falling edge and samples the outputs on the next falling edge, which is half a cycle after the edge that produces them. For the error pulse, the bench samples one more falling edge to check that the pulse has dropped.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_FAULT = 2'd3
    } acc_state_e;

    localparam int unsigned VIEW_LAST    = 7;
    localparam int unsigned SEL_MSP      = 8;
    localparam int unsigned SEL_PSP      = 9;
    localparam int unsigned SEL_PRIM     = 16;
    localparam int unsigned SEL_BPRI     = 17;
    localparam int unsigned SEL_BPRI_MAX = 18;
    localparam int unsigned SEL_FMASK    = 19;
    localparam int unsigned SEL_CTRL     = 20;

    localparam logic [31:0] FLAG_MASK   = 32'hF800_0000;
    localparam logic [31:0] EXC_MASK    = 32'h0000_01FF;
    localparam logic [31:0] XSTATE_MASK = 32'h0700_FC00;

    function automatic logic sel_known(input int unsigned s);
        return (s <= SEL_PSP) || ((s >= SEL_PRIM) && (s <= SEL_CTRL));
    endfunction

endpackage

// File: rtl/sreg_store.sv
module sreg_store
    import sreg_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned SEL_W  = 8,
    parameter int unsigned PRIO_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_go,
    input  logic [SEL_W-1:0]  sel,
    input  logic              priv,
    input  logic [DATA_W-1:0] wdata,
    input  logic              xs_load,
    input  logic [DATA_W-1:0] xs_data,
    output logic [DATA_W-1:0] psr,
    output logic [DATA_W-1:0] sp_live,
    output logic [DATA_W-1:0] sp_bank,
    output logic [1:0]        ctl,
    output logic              primask,
    output logic              faultmask,
    output logic [PRIO_W-1:0] basepri
);

    localparam logic [DATA_W-1:0] FLG_M = DATA_W'(FLAG_MASK);
    localparam logic [DATA_W-1:0] SIDE_M = DATA_W'(EXC_MASK | XSTATE_MASK);

    logic              view_wr;
    logic              priv_wr;
    logic [DATA_W-1:0] psr_nxt;
    logic [PRIO_W-1:0] bp_new;
    logic              bp_raise;
    logic              sp_swap;

    assign view_wr  = wr_go && (sel <= SEL_W'(VIEW_LAST));
    assign priv_wr  = wr_go && priv;
    assign bp_new   = wdata[PRIO_W-1:0];
    assign bp_raise = (bp_new != '0) && ((basepri == '0) || (bp_new < basepri));
    assign sp_swap  = priv_wr && (sel == SEL_W'(SEL_CTRL)) && (wdata[1] != ctl[1]);

    always_comb begin
        psr_nxt = psr;
        if (view_wr) begin
            psr_nxt = (psr_nxt & ~FLG_M) | (wdata & FLG_M);
        end
        if (xs_load) begin
            psr_nxt = (psr_nxt & ~SIDE_M) | (xs_data & SIDE_M);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psr <= '0;
        end else begin
            psr <= psr_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_live   <= '0;
            sp_bank   <= '0;
            ctl       <= '0;
            primask   <= 1'b0;
            faultmask <= 1'b0;
            basepri   <= '0;
        end else if (sp_swap) begin
            sp_live <= sp_bank;
            sp_bank <= sp_live;
            ctl     <= wdata[1:0];
        end else if (priv_wr) begin
            unique case (sel)
                SEL_W'(SEL_MSP): begin
                    if (ctl[1]) sp_bank <= wdata;
                    else        sp_live <= wdata;
                end
                SEL_W'(SEL_PSP): begin
                    if (ctl[1]) sp_live <= wdata;
                    else        sp_bank <= wdata;
                end
                SEL_W'(SEL_PRIM):  primask   <= wdata[0];
                SEL_W'(SEL_BPRI):  basepri   <= bp_new;
                SEL_W'(SEL_BPRI_MAX): begin
                    if (bp_raise) basepri <= bp_new;
                end
                SEL_W'(SEL_FMASK): faultmask <= wdata[0];
                SEL_W'(SEL_CTRL):  ctl       <= wdata[1:0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/sreg_view_mux.sv
module sreg_view_mux
    import sreg_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned SEL_W  = 8,
    parameter int unsigned PRIO_W = 8
) (
    input  logic [SEL_W-1:0]  sel,
    input  logic              priv,
    input  logic [DATA_W-1:0] psr,
    input  logic [DATA_W-1:0] sp_live,
    input  logic [DATA_W-1:0] sp_bank,
    input  logic [1:0]        ctl,
    input  logic              primask,
    input  logic              faultmask,
    input  logic [PRIO_W-1:0] basepri,
    output logic [DATA_W-1:0] value,
    output logic              known
);

    logic [DATA_W-1:0] view_mask;
    logic [DATA_W-1:0] bp_ext;

    generate
        if (PRIO_W < DATA_W) begin : g_bp_pad
            assign bp_ext = {{(DATA_W-PRIO_W){1'b0}}, basepri};
        end else begin : g_bp_full
            assign bp_ext = basepri[DATA_W-1:0];
        end
    endgenerate

    assign known = sel_known(int'(sel));

    always_comb begin
        view_mask = '0;
        if (!sel[2])           view_mask = view_mask | DATA_W'(FLAG_MASK);
        if (sel[0] && priv)    view_mask = view_mask | DATA_W'(EXC_MASK);
    end

    always_comb begin
        value = '0;
        if (sel <= SEL_W'(VIEW_LAST)) begin
            value = psr & view_mask;
        end else if (sel == SEL_W'(SEL_CTRL)) begin
            value = {{(DATA_W-2){1'b0}}, ctl};
        end else if (priv) begin
            unique case (sel)
                SEL_W'(SEL_MSP):      value = ctl[1] ? sp_bank : sp_live;
                SEL_W'(SEL_PSP):      value = ctl[1] ? sp_live : sp_bank;
                SEL_W'(SEL_PRIM):     value = {{(DATA_W-1){1'b0}}, primask};
                SEL_W'(SEL_BPRI):     value = bp_ext;
                SEL_W'(SEL_BPRI_MAX): value = bp_ext;
                SEL_W'(SEL_FMASK):    value = {{(DATA_W-1){1'b0}}, faultmask};
                default:              value = '0;
            endcase
        end
    end

endmodule

// File: rtl/sreg_seq_fsm.sv
module sreg_seq_fsm
    import sreg_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic              priv,
    input  logic              known,
    input  logic [DATA_W-1:0] value,
    output logic              wr_go,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              sel_err
);

    acc_state_e state_q;
    acc_state_e state_d;

    always_comb begin
        if ((rd_en || wr_en) && priv && !known) state_d = ST_FAULT;
        else if (wr_en)                         state_d = ST_WRITE;
        else if (rd_en)                         state_d = ST_READ;
        else                                    state_d = ST_IDLE;
    end

    assign wr_go = (state_d == ST_WRITE);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else begin
            unique case (state_d)
                ST_READ:  rd_data <= value;
                ST_IDLE,
                ST_WRITE,
                ST_FAULT: rd_data <= '0;
            endcase
        end
    end

    assign rd_valid = (state_q == ST_READ);
    assign sel_err  = (state_q == ST_FAULT);

endmodule

// File: rtl/sreg_access_unit.sv
module sreg_access_unit
    import sreg_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned SEL_W  = 8,
    parameter int unsigned PRIO_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  sel,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              priv,
    input  logic              xs_load,
    input  logic [DATA_W-1:0] xs_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              sel_err
);

    logic [DATA_W-1:0] psr;
    logic [DATA_W-1:0] sp_live;
    logic [DATA_W-1:0] sp_bank;
    logic [1:0]        ctl;
    logic              primask;
    logic              faultmask;
    logic [PRIO_W-1:0] basepri;
    logic [DATA_W-1:0] value;
    logic              known;
    logic              wr_go;

    sreg_seq_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .wr_en    (wr_en),
        .priv     (priv),
        .known    (known),
        .value    (value),
        .wr_go    (wr_go),
        .rd_data  (rd_data),
        .rd_valid (rd_valid),
        .sel_err  (sel_err)
    );

    sreg_store #(.DATA_W(DATA_W), .SEL_W(SEL_W), .PRIO_W(PRIO_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_go     (wr_go),
        .sel       (sel),
        .priv      (priv),
        .wdata     (wr_data),
        .xs_load   (xs_load),
        .xs_data   (xs_data),
        .psr       (psr),
        .sp_live   (sp_live),
        .sp_bank   (sp_bank),
        .ctl       (ctl),
        .primask   (primask),
        .faultmask (faultmask),
        .basepri   (basepri)
    );

    sreg_view_mux #(.DATA_W(DATA_W), .SEL_W(SEL_W), .PRIO_W(PRIO_W)) u_mux (
        .sel       (sel),
        .priv      (priv),
        .psr       (psr),
        .sp_live   (sp_live),
        .sp_bank   (sp_bank),
        .ctl       (ctl),
        .primask   (primask),
        .faultmask (faultmask),
        .basepri   (basepri),
        .value     (value),
        .known     (known)
    );

endmodule

// File: rtl/sreg_access_chk.sv
module sreg_access_chk #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned SEL_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [SEL_W-1:0]  sel,
    input logic              rd_en,
    input logic              wr_en,
    input logic              priv,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_valid,
    input logic              sel_err
);

    logic unknown_sel;
    assign unknown_sel = ((sel > SEL_W'(9)) && (sel < SEL_W'(16))) || (sel > SEL_W'(20));

    // R12
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_err |-> $past(priv && (rd_en || wr_en) && unknown_sel));

    // R12
    err_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_err |-> (!rd_valid && rd_data == '0));

    // R6
    unpriv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && !priv && sel > SEL_W'(7) && sel != SEL_W'(20))
        |=> (rd_valid && rd_data == '0 && !sel_err));

    // R4
    xstate_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && sel <= SEL_W'(7)) |=> ((rd_data & DATA_W'(32'h0700_FC00)) == '0));

    // R9
    fmask_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && sel == SEL_W'(19)) |=> (rd_data[DATA_W-1:1] == '0));

    // R13
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && wr_en) |=> !rd_valid);

endmodule

bind sreg_access_unit sreg_access_chk #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (sel),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .priv     (priv),
    .rd_data  (rd_data),
    .rd_valid (rd_valid),
    .sel_err  (sel_err)
);

// File: tb/test_sreg_access_unit.sv
`timescale 1ns/1ps
module test_sreg_access_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  sel = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        priv = 1'b0;
    logic        xs_load = 1'b0;
    logic [31:0] xs_data = '0;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic        sel_err;

    int total = 0;
    int bad = 0;
    logic [31:0] got_d;
    logic        got_v;
    logic        got_e;

    always #2.5 clk = ~clk;

    sreg_access_unit i_sreg_access_unit (
        .clk(clk), .rst_n(rst_n), .sel(sel), .rd_en(rd_en), .wr_en(wr_en),
        .wr_data(wr_data), .priv(priv), .xs_load(xs_load), .xs_data(xs_data),
        .rd_data(rd_data), .rd_valid(rd_valid), .sel_err(sel_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic [7:0] s, input logic r, input logic w,
                          input logic [31:0] d, input logic p);
        @(negedge clk);
        sel = s; rd_en = r; wr_en = w; wr_data = d; priv = p;
        @(negedge clk);
        got_d = rd_data; got_v = rd_valid; got_e = sel_err;
        rd_en = 1'b0; wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] s, input logic p, input string req, input logic [31:0] exp);
        access(s, 1'b1, 1'b0, '0, p);
        check(req, got_d, exp);
        check(req, {31'b0, got_v}, 32'd1);
    endtask

    task automatic wr(input logic [7:0] s, input logic [31:0] d, input logic p);
        access(s, 1'b0, 1'b1, d, p);
    endtask

    task automatic t_reset();
        check("R1 rd_valid", {31'b0, rd_valid}, 0);
        check("R1 sel_err", {31'b0, sel_err}, 0);
        check("R1 rd_data", rd_data, 0);
        rd(8'd3, 1'b1, "R1 status", 32'h0);
        rd(8'd20, 1'b1, "R1 control", 32'h0);
        rd(8'd17, 1'b1, "R1 basepri", 32'h0);
    endtask

    task automatic t_status();
        @(negedge clk);
        xs_load = 1'b1; xs_data = 32'hFFFF_FFFF & ~32'hF800_0000 | 32'h0000_01A5 & 32'h0700_FDFF;
        xs_data = 32'h0700_FDA5;
        @(negedge clk);
        xs_load = 1'b0;
        wr(8'd0, 32'hFFFF_FFFF, 1'b1);
        // R2 latency: data one edge after strobe, valid for one cycle
        access(8'd3, 1'b1, 1'b0, '0, 1'b1);
        check("R2 R3 sel3", got_d, 32'hF800_01A5);
        check("R2 valid", {31'b0, got_v}, 1);
        @(negedge clk);
        check("R2 valid drops", {31'b0, rd_valid}, 0);
        rd(8'd0, 1'b1, "R3 sel0", 32'hF800_0000);
        rd(8'd5, 1'b1, "R3 sel5", 32'h0000_01A5);
        rd(8'd4, 1'b1, "R3 sel4", 32'h0);
        rd(8'd7, 1'b1, "R4 sel7", 32'h0000_01A5);
        rd(8'd1, 1'b0, "R3 unpriv sel1", 32'hF800_0000);
        rd(8'd5, 1'b0, "R3 unpriv sel5", 32'h0);
    endtask

    task automatic t_flag_write();
        wr(8'd2, 32'h57FF_FFFF, 1'b0);
        rd(8'd3, 1'b1, "R5 unpriv flag write", 32'h5000_01A5);
        wr(8'd6, 32'h0000_0000, 1'b1);
        rd(8'd3, 1'b1, "R5 priv zero flags", 32'h0000_01A5);
    endtask

    task automatic t_stack();
        wr(8'd8, 32'h2000_1000, 1'b1);
        wr(8'd9, 32'h2000_2000, 1'b1);
        rd(8'd8, 1'b1, "R7 msp", 32'h2000_1000);
        rd(8'd9, 1'b1, "R7 psp", 32'h2000_2000);
        wr(8'd20, 32'hFFFF_FFFE, 1'b1);
        rd(8'd20, 1'b0, "R8 control unpriv read", 32'h2);
        rd(8'd8, 1'b1, "R7 msp after switch", 32'h2000_1000);
        rd(8'd9, 1'b1, "R7 psp after switch", 32'h2000_2000);
        wr(8'd9, 32'h2000_3000, 1'b1);
        rd(8'd8, 1'b0, "R6 unpriv msp", 32'h0);
        wr(8'd8, 32'hDEAD_BEEF, 1'b0);
        wr(8'd20, 32'h0, 1'b0);
        rd(8'd20, 1'b1, "R8 unpriv ctl write ignored", 32'h2);
        wr(8'd20, 32'h0, 1'b1);
        rd(8'd8, 1'b1, "R6 R7 msp kept", 32'h2000_1000);
        rd(8'd9, 1'b1, "R7 psp kept", 32'h2000_3000);
    endtask

    task automatic t_masks();
        wr(8'd16, 32'hFFFF_FFFF, 1'b1);
        rd(8'd16, 1'b1, "R9 primask", 32'h1);
        wr(8'd19, 32'h3, 1'b1);
        rd(8'd19, 1'b1, "R9 faultmask", 32'h1);
        rd(8'd19, 1'b0, "R6 unpriv faultmask", 32'h0);
        wr(8'd17, 32'h1FF, 1'b1);
        rd(8'd17, 1'b1, "R10 basepri", 32'hFF);
        wr(8'd18, 32'h40, 1'b1);
        rd(8'd17, 1'b1, "R11 lower", 32'h40);
        wr(8'd18, 32'h80, 1'b1);
        rd(8'd17, 1'b1, "R11 higher ignored", 32'h40);
        wr(8'd18, 32'h0, 1'b1);
        rd(8'd18, 1'b1, "R11 zero ignored", 32'h40);
        wr(8'd17, 32'h0, 1'b1);
        wr(8'd18, 32'h90, 1'b1);
        rd(8'd17, 1'b1, "R11 from zero", 32'h90);
    endtask

    task automatic t_unknown();
        access(8'd12, 1'b1, 1'b0, '0, 1'b1);
        check("R12 err", {31'b0, got_e}, 1);
        check("R12 no valid", {31'b0, got_v}, 0);
        check("R12 data", got_d, 0);
        @(negedge clk);
        check("R12 pulse one cycle", {31'b0, sel_err}, 0);
        access(8'd200, 1'b0, 1'b1, 32'hFFFF_FFFF, 1'b1);
        check("R12 write err", {31'b0, got_e}, 1);
        rd(8'd3, 1'b1, "R12 state kept", 32'h0000_01A5);
        access(8'd12, 1'b1, 1'b0, '0, 1'b0);
        check("R6 unpriv unknown no err", {31'b0, got_e}, 0);
        check("R6 unpriv unknown data", got_d, 0);
    endtask

    task automatic t_both();
        access(8'd16, 1'b1, 1'b1, 32'h0, 1'b1);
        check("R13 no read response", {31'b0, got_v}, 0);
        rd(8'd16, 1'b1, "R13 write done", 32'h0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_status();
        t_flag_write();
        t_stack();
        t_masks();
        t_unknown();
        t_both();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule